// File: doc/BRIEF.md
# Top-Octave Tone Divider Bank

This block turns one fast master clock into a full bank of square-wave semitone tones for an electronic instrument. Twelve independent integer dividers each make one note of the highest octave. Every divider has its own half-period constant, which is worked out ahead of time and passed in as a parameter. Twelve dividers that each use a different period approximate the irrational semitone ratios. The error shrinks as the master clock gets faster relative to the tones.

Each top-octave tone drives a chain of divide-by-two stages, one per lower octave. Each stage is an ordinary flip-flop on the master clock. A one-cycle step pulse enables it, so no derived clocks exist. Every lower octave is therefore exactly half the frequency of the octave above. All outputs come straight from flip-flops.

Top module: `tonebank`

## Requirements
- R1: While `rst_n` is low, every bit of `tone_o` is 0. This holds from the moment reset is asserted, without waiting for a clock edge, and covers every divider count and every halving stage.
- R2: Let D_k be the half-period constant of semitone k, taken from field k (bits k*CNT_W and up) of `HALF_PER`. Top-octave output bit k of `tone_o` goes high on the D_k-th rising clock edge after reset release. After that it inverts every D_k edges, so its period is 2*D_k master cycles.
- R3: A constant of 1 makes the top-octave output invert on every edge, a period of 2 cycles. The largest constant, 2^CNT_W-1, gives a period of 2*(2^CNT_W-1) cycles. Both follow the rule in R2 with no wrap error.
- R4: Output bit o*12+k is octave o of semitone k, where octave 0 is the top. It starts low, goes high on edge D_k*2^o after reset release, and then inverts every D_k*2^o edges. Its frequency is exactly half that of octave o-1.
- R5: Octave o (o >= 1) of a semitone changes state on exactly those clock edges where octave o-1 of the same semitone falls from 1 to 0, and on no other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all dividers and halving stages run on it |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released in step with `clk` |
| tone_o | output | NUM_OCT*12 | Tone outputs; bit o*12+k is octave o (0 = top) of semitone k |

## Verification
The bench builds the bank with a 4-bit divider width and three octaves. The twelve half-period constants are 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 13 and 15. This brings both ends of the divisor range, and twelve distinct periods, into one short run. The longest full cycle, at the bottom octave of constant 15, is 120 master cycles, so every output can be compared against its arithmetic expectation on every cycle over several complete periods. A reset asserted in the middle of a cycle, followed by a second sweep, shows the clear and the restart phase.

// File: rtl/tonebank_pkg.sv
package tonebank_pkg;
  // Notes per octave.
  localparam int unsigned SEMIS = 12;
endpackage

// File: rtl/tone_div.sv
// One top-octave divider: inverts its output every HALF master cycles and
// flags the cycle in which its count wraps.
module tone_div #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned HALF  = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic q_o,
  output logic wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tog_q, tog_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    tog_d = tog_q ^ wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign q_o    = tog_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/oct_stage.sv
// One halving stage: a flip-flop that inverts when its step enable is high.
module oct_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb q_d = q_q ^ step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/tonebank.sv
module tonebank
  import tonebank_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_OCT = 8,
  // Field k (k*CNT_W +: CNT_W) is the half period of semitone k, in master cycles.
  parameter logic [12*CNT_W-1:0] HALF_PER = {
    16'd127, 16'd134, 16'd142, 16'd150, 16'd159, 16'd169,
    16'd179, 16'd190, 16'd201, 16'd213, 16'd225, 16'd239}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [NUM_OCT*SEMIS-1:0] tone_o
);
  localparam int unsigned NUM_OUT = NUM_OCT * SEMIS;

  logic [NUM_OUT-1:0] tone_w;

  for (genvar k = 0; k < SEMIS; k++) begin : g_semi
    logic [NUM_OCT-1:0] q_oct;
    logic [NUM_OCT-1:0] step;

    tone_div #(
      .CNT_W (CNT_W),
      .HALF  (int'(HALF_PER[k*CNT_W +: CNT_W]))
    ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .q_o    (q_oct[0]),
      .wrap_o (step[0])
    );

    // A lower octave steps when the octave above is about to fall.
    for (genvar o = 1; o < NUM_OCT; o++) begin : g_oct
      assign step[o] = step[o-1] & q_oct[o-1];

      oct_stage u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step[o]),
        .q_o    (q_oct[o])
      );
    end

    for (genvar o = 0; o < NUM_OCT; o++) begin : g_out
      assign tone_w[o*SEMIS + k] = q_oct[o];
    end
  end

  assign tone_o = tone_w;
endmodule

// File: rtl/tonebank_chk.sv
module tonebank_chk
  import tonebank_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_OCT = 8,
  parameter logic [12*CNT_W-1:0] HALF_PER = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_OCT*SEMIS-1:0] tone
);
  // R1: outputs are low whenever reset is held.
  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> (tone == '0));

  for (genvar k = 0; k < SEMIS; k++) begin : g_k
    logic             prev;
    logic [CNT_W:0]   run;
    localparam logic [CNT_W:0] HALF_X = (CNT_W+1)'(HALF_PER[k*CNT_W +: CNT_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev <= 1'b0;
        run  <= '0;
      end else begin
        prev <= tone[k];
        run  <= (tone[k] != prev) ? (CNT_W+1)'(1) : run + 1'b1;
      end
    end

    // R2: each top-octave level lasts exactly its half-period constant.
    p_top_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tone[k] != prev) |-> (run == HALF_X));

    for (genvar o = 1; o < NUM_OCT; o++) begin : g_o
      // R5: a lower octave changes only where the octave above falls.
      p_follow_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(tone[o*SEMIS+k]) |-> $fell(tone[(o-1)*SEMIS+k]));
      // R4: every fall of the octave above steps the octave below.
      p_halving_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tone[(o-1)*SEMIS+k]) |-> $changed(tone[o*SEMIS+k]));
    end
  end
endmodule

bind tonebank tonebank_chk #(
  .CNT_W    (CNT_W),
  .NUM_OCT  (NUM_OCT),
  .HALF_PER (HALF_PER)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tone  (tone_o)
);

// File: tb/tonebank_bench.sv
module tonebank_bench;
  localparam int unsigned CW  = 4;
  localparam int unsigned NO  = 3;
  localparam int unsigned NS  = 12;
  localparam logic [12*CW-1:0] HP = {
    4'd15, 4'd13, 4'd10, 4'd9, 4'd8, 4'd7,
    4'd6,  4'd5,  4'd4,  4'd3, 4'd2, 4'd1};

  logic              clk;
  logic              rst_n;
  logic [NO*NS-1:0]  tone;
  logic [NO*NS-1:0]  last;
  int                n_run;
  int                n_fail;
  bit                done;

  tonebank #(.CNT_W(CW), .NUM_OCT(NO), .HALF_PER(HP)) u_tonebank (
    .clk    (clk),
    .rst_n  (rst_n),
    .tone_o (tone)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp_v,
                       input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // Expected level of octave o of semitone k, t edges after reset release.
  function automatic bit exp_lvl(int k, int o, int t);
    int d;
    d = int'(HP[k*CW +: CW]) << o;
    return ((t / d) % 2) == 1;
  endfunction

  task automatic sweep(input int cycles);
    last = tone;
    for (int t = 1; t <= cycles; t++) begin
      @(negedge clk);
      for (int o = 0; o < NO; o++) begin
        for (int k = 0; k < NS; k++) begin
          int  d;
          bit  e;
          string tag;
          d = int'(HP[k*CW +: CW]);
          e = exp_lvl(k, o, t);
          if (o > 0)                  tag = "R4";
          else if (d == 1 || d == 15) tag = "R3";
          else                        tag = "R2";
          check(tone[o*NS+k] == e, tag, int'(tone[o*NS+k]), int'(e),
                $sformatf("oct %0d semi %0d edge %0d", o, k, t));
          if (o > 0 && tone[o*NS+k] != last[o*NS+k]) begin
            // R5: a change below needs a fall just above on the same edge.
            check(last[(o-1)*NS+k] && !tone[(o-1)*NS+k], "R5",
                  int'(tone[(o-1)*NS+k]), 0,
                  $sformatf("oct %0d semi %0d edge %0d", o, k, t));
          end
        end
      end
      last = tone;
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tone == '0, "R1", int'(tone), 0, "outputs under power-on reset");
    rst_n = 1'b1;
    sweep(260);
    // Asynchronous reset in the middle of a cycle.
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check(tone == '0, "R1", int'(tone), 0, "outputs right after async reset");
    repeat (2) @(negedge clk);
    check(tone == '0, "R1", int'(tone), 0, "outputs while reset held");
    rst_n = 1'b1;
    sweep(130);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule